// File: doc/BRIEF.md
# Burst address sequencer and cycle decoder

This block sits at the front of a synchronous burst SRAM. It samples the address bus, three chip enables, two burst-start strobes, an advance input, a burst-order pin and the write controls on every rising clock edge. From these it resolves the operation of the cycle: idle (deselect), read or write. It also produces the word address the memory array must use and the per-lane write mask. The memory array and the output drivers are outside the block.

There are two start strobes. The processor strobe always starts a read and is masked by the first chip enable. The controller strobe starts either a read or a write, as the write controls select. When neither strobe is active, the advance input either steps the burst or holds it on the current word. A burst covers a group of four words. The low two address bits follow either a linear or an interleaved order, and the count never carries into the upper address bits.

Every output is registered. The values seen after rising edge k describe the cycle whose inputs were sampled at edge k.

Top module: `burst_cycle_unit`

## Requirements
- R1: While `rstN` is low, `cycleOp` is 0, `memAddr` is 0 and both masks are 0. After reset the burst order register holds the interleaved setting. Each output changes one rising edge after the inputs it depends on are sampled. `cycleOp` encodes idle as 2'b00, read as 2'b01 and write as 2'b10.
- R2: The chip counts as selected only when `chipSelAN`=0, `chipSelB`=1 and `chipSelCN`=0. A cycle is idle, with zero masks and an unchanged address, in two cases: `ctrlStartN`=0 with `chipSelAN`=1, or either strobe effectively low while the chip is not selected.
- R3: `procStartN`=0 while the chip is selected starts a read at `addrIn`, with both masks 0, whatever the write inputs are.
- R4: `chipSelAN`=1 masks `procStartN`. With `ctrlStartN`=1 the cycle then behaves as a continue or a suspend cycle.
- R5: `procStartN`=1 and `ctrlStartN`=0 while selected starts a burst at `addrIn`. The cycle is a write if the write function of R6 names any lane, otherwise a read.
- R6: Lane mask bit i stands for lane i. If `globalWrN`=0, all lanes are written. Otherwise, if `byteWrEnN`=0, lane i is written when `laneWrN[i]`=0. Otherwise no lane is written.
- R7: With both strobes effectively high and `advanceN`=0, the burst count steps by one. The cycle is a write with the R6 mask if any lane is named, otherwise a read.
- R8: With both strobes effectively high and `advanceN`=1, the address stays the same as in the previous cycle (a wait cycle).
- R9: If `orderSel` was 0 when the burst started, the low two address bits are (start + count) mod 4.
- R10: If `orderSel` was 1 when the burst started, the low two address bits are start XOR count.
- R11: The count wraps after four steps, back to the start word. Only a new burst start changes `memAddr[17:2]`.
- R12: `bitMask` bits 0..7 and bit 16 follow lane 0. Bits 8..15 and bit 17 follow lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | 18 | External word address |
| chipSelAN | input | 1 | Chip enable, active low; also masks the processor strobe |
| chipSelB | input | 1 | Chip enable, active high |
| chipSelCN | input | 1 | Chip enable, active low |
| procStartN | input | 1 | Processor burst-start strobe, active low, read only |
| ctrlStartN | input | 1 | Controller burst-start strobe, active low |
| advanceN | input | 1 | Low steps the burst, high suspends it |
| orderSel | input | 1 | 0 = linear order, 1 = interleaved order |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enables the per-lane write inputs, active low |
| laneWrN | input | 2 | Per-lane write inputs, active low |
| cycleOp | output | 2 | Resolved operation: 00 idle, 01 read, 10 write |
| memAddr | output | 18 | Address the memory array uses this cycle |
| laneMask | output | 2 | Lanes written this cycle |
| bitMask | output | 18 | Per-bit write mask including parity bits |

## Verification
The bench builds the block with its defaults: an 18-bit address, a 2-bit burst count and two 9-bit lanes. With a 2-bit count, every start value in both orders and a full wrap back to the start word take only five cycles to reach. An all-ones upper address makes any stray carry out of the count visible at once. Random cycles with biased strobe and enable probabilities reach every row of the decode table, including masked processor strobes and write-type continue cycles.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } cycOp_t;

  typedef struct packed {
    logic load;  // capture external address, clear count
    logic step;  // advance burst count
  } seqStrobe_t;
endpackage

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int LANE_DATA = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           chipSelAN,
  input  logic                           chipSelB,
  input  logic                           chipSelCN,
  input  logic                           procStartN,
  input  logic                           ctrlStartN,
  input  logic                           advanceN,
  input  logic                           globalWrN,
  input  logic                           byteWrEnN,
  input  logic [LANES-1:0]               laneWrN,
  output seqStrobe_t                     strb,
  output logic [1:0]                     cycleOp,
  output logic [LANES-1:0]               laneMask,
  output logic [LANES*(LANE_DATA+1)-1:0] bitMask
);
  localparam int DATA_BITS = LANES * LANE_DATA;

  logic             selOk;
  logic             procHit;
  logic [LANES-1:0] wrLanes;
  cycOp_t           opNext;
  logic [LANES-1:0] maskNext;
  cycOp_t           opReg;
  logic [LANES-1:0] maskReg;

  assign selOk   = !chipSelAN && chipSelB && !chipSelCN;
  assign procHit = !procStartN && !chipSelAN;

  always_comb begin
    if (!globalWrN)      wrLanes = '1;
    else if (!byteWrEnN) wrLanes = ~laneWrN;
    else                 wrLanes = '0;
  end

  always_comb begin
    strb     = '0;
    opNext   = OP_IDLE;
    maskNext = '0;
    if (procHit) begin
      if (selOk) begin
        strb.load = 1'b1;
        opNext    = OP_READ;
      end
    end else if (!ctrlStartN) begin
      if (selOk) begin
        strb.load = 1'b1;
        maskNext  = wrLanes;
        opNext    = (|wrLanes) ? OP_WRITE : OP_READ;
      end
    end else begin
      strb.step = !advanceN;
      maskNext  = wrLanes;
      opNext    = (|wrLanes) ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= OP_IDLE;
      maskReg <= '0;
    end else begin
      opReg   <= opNext;
      maskReg <= maskNext;
    end
  end

  assign cycleOp  = opReg;
  assign laneMask = maskReg;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bitMask[l*LANE_DATA +: LANE_DATA] = {LANE_DATA{maskReg[l]}};
    assign bitMask[DATA_BITS + l]            = maskReg[l];
  end

  // R3
  proc_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStartN && !chipSelAN && chipSelB && !chipSelCN)
      |=> (cycleOp == OP_READ && laneMask == '0));

  // R2
  masked_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelAN && !ctrlStartN) |=> (cycleOp == OP_IDLE && laneMask == '0));

  // R6
  mask_only_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleOp != OP_WRITE) |-> (laneMask == '0));
endmodule

// File: rtl/bcu_dpath.sv
module bcu_dpath
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  baseHi;
  logic [CNT_W-1:0] startLo;
  logic [CNT_W-1:0] cnt;
  logic             orderReg;
  logic [CNT_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi   <= '0;
      startLo  <= '0;
      cnt      <= '0;
      orderReg <= 1'b1;
    end else if (strb.load) begin
      baseHi   <= addrIn[ADDR_W-1:CNT_W];
      startLo  <= addrIn[CNT_W-1:0];
      cnt      <= '0;
      orderReg <= orderSel;
    end else if (strb.step) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lowBits = orderReg ? (startLo ^ cnt) : CNT_W'(startLo + cnt);
  assign memAddr = {baseHi, lowBits};

  // R5
  load_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (memAddr == $past(addrIn)));

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(memAddr));

  // R11
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(memAddr[ADDR_W-1:CNT_W]));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/burst_cycle_unit.sv
module burst_cycle_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CNT_W     = 2,
  parameter int LANES     = 2,
  parameter int LANE_DATA = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addrIn,
  input  logic                           chipSelAN,
  input  logic                           chipSelB,
  input  logic                           chipSelCN,
  input  logic                           procStartN,
  input  logic                           ctrlStartN,
  input  logic                           advanceN,
  input  logic                           orderSel,
  input  logic                           globalWrN,
  input  logic                           byteWrEnN,
  input  logic [LANES-1:0]               laneWrN,
  output logic [1:0]                     cycleOp,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [LANES-1:0]               laneMask,
  output logic [LANES*(LANE_DATA+1)-1:0] bitMask
);
  seqStrobe_t strb;

  bcu_ctrl #(.LANES(LANES), .LANE_DATA(LANE_DATA)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .chipSelAN(chipSelAN), .chipSelB(chipSelB), .chipSelCN(chipSelCN),
    .procStartN(procStartN), .ctrlStartN(ctrlStartN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .strb(strb), .cycleOp(cycleOp), .laneMask(laneMask), .bitMask(bitMask)
  );

  bcu_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .addrIn(addrIn), .orderSel(orderSel), .memAddr(memAddr)
  );
endmodule

// File: tb/sim_burst_cycle_unit.sv
module sim_burst_cycle_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] addrIn = '0;
  logic        chipSelAN = 1'b1, chipSelB = 1'b1, chipSelCN = 1'b0;
  logic        procStartN = 1'b1, ctrlStartN = 1'b1, advanceN = 1'b1;
  logic        orderSel = 1'b1, globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [1:0]  laneWrN = 2'b11;
  logic [1:0]  cycleOp;
  logic [17:0] memAddr;
  logic [1:0]  laneMask;
  logic [17:0] bitMask;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [17:0] mBase = '0;
  logic [1:0]  mCnt = '0;
  logic        mOrder = 1'b1;

  always #10 clk = ~clk;

  burst_cycle_unit u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .chipSelAN(chipSelAN), .chipSelB(chipSelB), .chipSelCN(chipSelCN),
    .procStartN(procStartN), .ctrlStartN(ctrlStartN), .advanceN(advanceN),
    .orderSel(orderSel), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .cycleOp(cycleOp), .memAddr(memAddr),
    .laneMask(laneMask), .bitMask(bitMask)
  );

  function automatic logic [1:0] expLanes(logic gw, logic bwe, logic [1:0] lw);
    if (!gw) return 2'b11;
    if (!bwe) return ~lw;
    return 2'b00;
  endfunction

  function automatic logic [17:0] expBits(logic [1:0] m);
    logic [17:0] b;
    for (int i = 0; i < 8; i++) begin
      b[i] = m[0];
      b[8+i] = m[1];
    end
    b[16] = m[0];
    b[17] = m[1];
    return b;
  endfunction

  function automatic logic [1:0] refLow(logic [1:0] s, int i, logic ord);
    int v;
    if (ord) v = int'(s) ^ i;
    else v = (int'(s) + i) % 4;
    return v[1:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drives one cycle, predicts, checks at the next falling edge.
  task automatic doCycle(input logic [17:0] a, input logic s1n, input logic s2, input logic s3n,
                         input logic pn, input logic cn, input logic advn, input logic ord,
                         input logic gwn, input logic bwen, input logic [1:0] lwn, input string tag);
    logic sel, pEff;
    logic [1:0] wl, eOp, eMask;
    addrIn = a; chipSelAN = s1n; chipSelB = s2; chipSelCN = s3n;
    procStartN = pn; ctrlStartN = cn; advanceN = advn; orderSel = ord;
    globalWrN = gwn; byteWrEnN = bwen; laneWrN = lwn;
    sel = !s1n && s2 && !s3n;
    pEff = !pn && !s1n;
    wl = expLanes(gwn, bwen, lwn);
    eOp = 2'b00; eMask = 2'b00;
    if (pEff) begin
      if (sel) begin
        eOp = 2'b01; mBase = a; mCnt = 0; mOrder = ord;
      end
    end else if (!cn) begin
      if (sel) begin
        eMask = wl; eOp = (wl != 0) ? 2'b10 : 2'b01;
        mBase = a; mCnt = 0; mOrder = ord;
      end
    end else begin
      eMask = wl; eOp = (wl != 0) ? 2'b10 : 2'b01;
      if (!advn) mCnt = mCnt + 2'd1;
    end
    @(negedge clk);
    chk(tag, "op", 32'(cycleOp), 32'(eOp));
    chk(tag, "addr", 32'(memAddr), 32'({mBase[17:2], refLow(mBase[1:0], int'(mCnt), mOrder)}));
    chk(tag, "laneMask", 32'(laneMask), 32'(eMask));
    chk(tag, "bitMask", 32'(bitMask), 32'(expBits(eMask)));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "op", 32'(cycleOp), 0);
    chk("R1", "addr", 32'(memAddr), 0);
    chk("R1", "laneMask", 32'(laneMask), 0);
    chk("R1", "bitMask", 32'(bitMask), 0);
    rstN = 1'b1;
    doCycle(18'h0, 1, 1, 0, 1, 1, 1, 1, 1, 1, 2'b11, "R8");

    // R9 / R10 / R11: every start value, both orders, full wrap
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [17:0] a;
        a = {16'hA5C3, 2'(s)};
        doCycle(a, 0, 1, 0, 1, 0, 1, 1'(o), 1, 1, 2'b11, "R5");
        for (int i = 1; i < 5; i++) begin
          doCycle(18'h0, 0, 1, 0, 1, 1, 0, ~1'(o), 1, 1, 2'b11, o ? "R10" : "R9");
          chk(o ? "R10" : "R9", "seq", 32'(memAddr[1:0]), 32'(refLow(2'(s), i % 4, 1'(o))));
        end
        chk("R11", "wrap", 32'(memAddr), 32'(a));
        doCycle(18'h1, 0, 1, 0, 1, 1, 1, 1'(o), 1, 1, 2'b11, "R8");
      end
    end
    // literal sequences
    doCycle(18'h1, 0, 1, 0, 1, 0, 1, 1, 1, 1, 2'b11, "R10");
    doCycle(18'h0, 0, 1, 0, 1, 1, 0, 1, 1, 1, 2'b11, "R10");
    chk("R10", "interleave 1->0", 32'(memAddr), 32'h0);
    doCycle(18'h3FFFF, 0, 1, 0, 1, 0, 1, 0, 1, 1, 2'b11, "R9");
    doCycle(18'h0, 0, 1, 0, 1, 1, 0, 1, 1, 1, 2'b11, "R11");
    chk("R11", "no carry", 32'(memAddr), 32'h3FFFC);

    // R3 processor start ignores write inputs
    doCycle(18'h12345, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R3");
    // R4 masked processor strobe acts as continue
    doCycle(18'h00F0F, 1, 1, 0, 0, 1, 0, 1, 1, 1, 2'b11, "R4");
    doCycle(18'h00F0F, 1, 1, 0, 0, 1, 1, 1, 1, 1, 2'b11, "R4");
    // R2 deselect rows
    doCycle(18'h2AAAA, 1, 1, 0, 1, 0, 0, 1, 0, 1, 2'b11, "R2");
    doCycle(18'h2AAAA, 0, 0, 0, 0, 1, 0, 1, 1, 1, 2'b11, "R2");
    doCycle(18'h2AAAA, 0, 1, 1, 0, 1, 0, 1, 1, 1, 2'b11, "R2");
    doCycle(18'h2AAAA, 0, 0, 0, 1, 0, 0, 1, 1, 1, 2'b11, "R2");
    doCycle(18'h2AAAA, 0, 1, 1, 1, 0, 0, 1, 0, 1, 2'b11, "R2");
    // R5 / R6 / R12 write decode
    doCycle(18'h00100, 0, 1, 0, 1, 0, 1, 0, 0, 1, 2'b11, "R6");
    chk("R12", "all bits", 32'(bitMask), 32'h3FFFF);
    doCycle(18'h00104, 0, 1, 0, 1, 0, 1, 0, 1, 0, 2'b00, "R6");
    doCycle(18'h00108, 0, 1, 0, 1, 0, 1, 0, 1, 0, 2'b10, "R12");
    chk("R12", "lane0 bits", 32'(bitMask), 32'h100FF);
    doCycle(18'h0010C, 0, 1, 0, 1, 0, 1, 0, 1, 0, 2'b01, "R12");
    chk("R12", "lane1 bits", 32'(bitMask), 32'h2FF00);
    doCycle(18'h00110, 0, 1, 0, 1, 0, 1, 0, 1, 0, 2'b11, "R5");
    doCycle(18'h00114, 0, 1, 0, 1, 0, 1, 0, 1, 1, 2'b00, "R5");
    // R7 write continue cycles
    doCycle(18'h0, 0, 1, 0, 1, 1, 0, 1, 1, 0, 2'b10, "R7");
    doCycle(18'h0, 1, 0, 1, 1, 1, 0, 1, 0, 1, 2'b11, "R7");

    // random cycles
    for (int n = 0; n < 600; n++) begin
      logic [17:0] a;
      logic [1:0] lw;
      a = 18'($urandom);
      lw = 2'($urandom);
      doCycle(a, ($urandom % 4) == 0, ($urandom % 5) != 0, ($urandom % 5) == 0,
              ($urandom % 5) != 0, ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
              ($urandom % 4) != 0, 1'($urandom), lw, "R7");
    end
    summary();
  end
endmodule